// File: doc/BRIEF.md
# Redundant 1.5-Bit Residue Stage Chain

This block is a bit-exact fixed-point model of a chain of redundant residue stages. It is meant for building and checking a digital correction unit before the analog pipeline exists. A signed sample enters with a valid flag. Each clock, every stage takes the residue left by the stage before it and sorts that value into one of three regions, using two thresholds placed symmetrically around zero. The stage then emits a two-bit code for the region. It also hands on a doubled residue, to which the reference has been added, not applied, or subtracted.

Each stage works on a different sample in the same cycle, so the chain accepts a new sample on every clock. Every stage adds its own code to a code word that travels with the sample. As a result, the code word that leaves the last stage holds every stage's decision for one and the same sample.

For test purposes, each stage can be built with a fixed offset on its thresholds. This mimics a misplaced comparator. The redundancy in the code then absorbs the error once the codes are recombined downstream.

Top module: `rsc_chain`

## Requirements
- R1: While `rst` is high at a rising clock edge, `codes_vld_o` goes low and `codes_o` goes to all zeros.
- R2: The reference is REF = 2^(FRAC_W-1) and the quarter step is Q = REF/4. A stage whose input x satisfies x < -Q emits code 00. For -Q <= x <= Q it emits 01. For x > Q it emits 10. Stage 0 sees the sample itself, and stage k's code sits at `codes_o[2k+1:2k]`.
- R3: The residue a stage passes on is 2x+REF after code 00, 2x after code 01 and 2x-REF after code 10. Residues are carried at FRAC_W+2 bits, and the sample is sign-extended to that width.
- R4: A residue that exceeds the range of the FRAC_W+2 bit signed residue is clamped to the nearest end of that range. The clamped value is what the next stage decides on.
- R5: One sample is accepted per valid cycle. The codes of a sample appear together with `codes_vld_o` exactly STAGES rising edges after the sample is taken, and samples leave in the order they entered.
- R6: A cycle with `sample_vld_i` low produces no output and does not disturb any sample in flight. While `codes_vld_o` is low, `codes_o` keeps its previous value.
- R7: Field k of `THR_OFS` is an OFF_W-bit two's complement value at bits [k*OFF_W +: OFF_W]. It is added to both thresholds of stage k and to no other stage.
- R8: Take any build whose offsets all have magnitude below Q, and any sample with |x| <= REF. Form the weighted sum of (code_k - 1) * 2^(STAGES-1-k) from its codes. That sum differs from the same sum in a zero-offset build by at most 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | FRAC_W+1 | Signed sample, FRAC_W fractional bits |
| sample_vld_i | input | 1 | Qualifies `sample_i` in this cycle |
| codes_o | output | 2*STAGES | Stage codes of one sample, stage k at bits [2k+1:2k] |
| codes_vld_o | output | 1 | `codes_o` carries a new sample this cycle |

## Verification
Two functions can fall in the same cycle: a stage can load a new sample while the output is holding codes through an idle cycle, and a residue can be clamped in the same cycle that the next stage's decision depends on it. The gapped sweep places idle input cycles between valid ones and changes the sample value on the idle cycles. The bench judges it by checking that the output keeps its codes on every idle output cycle and that the count and order of the outputs match the inputs. Full-scale samples force clamping in the second and third stages. The bench's arithmetic model clamps in the same way, and every code word is compared against that model, including the words from a second build carrying threshold offsets.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  // Region a stage assigns to its input
  typedef enum logic [1:0] {
    SC_LOW  = 2'b00,
    SC_MID  = 2'b01,
    SC_HIGH = 2'b10
  } step_code_e;

  // Reference action applied when forming the residue
  typedef enum logic [1:0] {
    RO_ADD  = 2'b00,
    RO_KEEP = 2'b01,
    RO_SUB  = 2'b10
  } res_op_e;

endpackage

// File: rtl/rsc_therm_decode.sv
// Two-comparator thermometer word to stage code and residue action.
module rsc_therm_decode
  import rsc_pkg::*;
(
  input  logic [1:0] therm_i,
  output step_code_e code_o,
  output res_op_e    op_o
);

  always_comb begin
    unique case (therm_i)
      2'b00: begin
        code_o = SC_LOW;
        op_o   = RO_ADD;
      end
      2'b11: begin
        code_o = SC_HIGH;
        op_o   = RO_SUB;
      end
      default: begin
        code_o = SC_MID;
        op_o   = RO_KEEP;
      end
    endcase
  end

endmodule

// File: rtl/rsc_residue.sv
// Doubling, reference add/subtract and saturation to the residue width.
module rsc_residue
  import rsc_pkg::*;
#(
  parameter int RES_W = 8,
  parameter int REF_I = 32
) (
  input  logic signed [RES_W-1:0] x_i,
  input  res_op_e                 op_i,
  output logic signed [RES_W-1:0] r_o
);

  localparam int WW    = RES_W + 2;
  localparam int MAX_I = (1 << (RES_W - 1)) - 1;
  localparam int MIN_I = -(1 << (RES_W - 1));
  localparam logic signed [WW-1:0] REF_W = WW'(REF_I);
  localparam logic signed [WW-1:0] MAX_W = WW'(MAX_I);
  localparam logic signed [WW-1:0] MIN_W = WW'(MIN_I);

  logic signed [WW-1:0] x_w;
  logic signed [WW-1:0] dbl;
  logic signed [WW-1:0] sum;

  always_comb begin
    x_w = WW'(x_i);
    dbl = x_w <<< 1;
    unique case (op_i)
      RO_ADD:  sum = dbl + REF_W;
      RO_SUB:  sum = dbl - REF_W;
      default: sum = dbl;
    endcase
    if (sum > MAX_W)      r_o = MAX_W[RES_W-1:0];
    else if (sum < MIN_W) r_o = MIN_W[RES_W-1:0];
    else                  r_o = sum[RES_W-1:0];
  end

endmodule

// File: rtl/rsc_stage.sv
// One registered stage: comparators, decode, residue, code word merge.
module rsc_stage
  import rsc_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int STAGES = 5,
  parameter int RES_W  = 8,
  parameter int REF_I  = 32,
  parameter int OFFSET = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      vld_i,
  input  logic signed [RES_W-1:0]   res_i,
  input  logic [2*STAGES-1:0]       codes_i,
  output logic                      vld_o,
  output logic signed [RES_W-1:0]   res_o,
  output logic [2*STAGES-1:0]       codes_o
);

  localparam int CW   = 2 * STAGES;
  localparam int WW   = RES_W + 2;
  localparam int QTR  = REF_I / 4;
  localparam int LO_I = -QTR + OFFSET;
  localparam int HI_I = QTR + OFFSET;
  localparam logic signed [WW-1:0] LO_W = WW'(LO_I);
  localparam logic signed [WW-1:0] HI_W = WW'(HI_I);

  logic signed [WW-1:0]    x_w;
  logic [1:0]              therm;
  step_code_e              code;
  res_op_e                 op;
  logic signed [RES_W-1:0] res_d;
  logic [CW-1:0]           codes_d;

  // comparators: bit 0 at the lower threshold, bit 1 at the upper one
  always_comb begin
    x_w      = WW'(res_i);
    therm[0] = (x_w >= LO_W);
    therm[1] = (x_w > HI_W);
  end

  rsc_therm_decode u_dec (
    .therm_i (therm),
    .code_o  (code),
    .op_o    (op)
  );

  rsc_residue #(
    .RES_W (RES_W),
    .REF_I (REF_I)
  ) u_res (
    .x_i  (res_i),
    .op_i (op),
    .r_o  (res_d)
  );

  // own slot of the incoming word is still zero, so OR merges it in
  always_comb codes_d = codes_i | (CW'(code) << (2 * IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o   <= 1'b0;
      res_o   <= '0;
      codes_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        res_o   <= res_d;
        codes_o <= codes_d;
      end
    end
  end

  // R2: lower comparator must trip before the upper one
  a_r2_thermo_legal: assert property (@(posedge clk) disable iff (rst)
    therm != 2'b10);

  // R3: stage code and residue action agree
  a_r3_code_op_pair: assert property (@(posedge clk) disable iff (rst)
    ((code == SC_LOW) == (op == RO_ADD)) && ((code == SC_HIGH) == (op == RO_SUB)));

  // R5: valid advances exactly one stage per edge
  a_r5_valid_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_o == $past(vld_i)));

  // R6: idle cycle leaves the stage contents alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(vld_i)) |-> ($stable(codes_o) && $stable(res_o)));

endmodule

// File: rtl/rsc_chain.sv
// Chain of redundant 1.5-bit residue stages with per-stage threshold offsets.
module rsc_chain #(
  parameter int                      FRAC_W  = 6,
  parameter int                      STAGES  = 5,
  parameter int                      OFF_W   = 6,
  parameter logic [STAGES*OFF_W-1:0] THR_OFS = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FRAC_W:0]       sample_i,
  input  logic                  sample_vld_i,
  output logic [2*STAGES-1:0]   codes_o,
  output logic                  codes_vld_o
);

  localparam int DATA_W = FRAC_W + 1;
  localparam int RES_W  = DATA_W + 1;
  localparam int REF_I  = 1 << (FRAC_W - 1);
  localparam int CW     = 2 * STAGES;
  localparam logic signed [RES_W-1:0] REF_S = RES_W'(REF_I);

  logic [STAGES:0]         vld_c;
  logic signed [RES_W-1:0] res_c  [STAGES+1];
  logic [CW-1:0]           code_c [STAGES+1];

  always_comb begin
    vld_c[0]  = sample_vld_i;
    res_c[0]  = {sample_i[DATA_W-1], sample_i};
    code_c[0] = '0;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam logic signed [OFF_W-1:0] OFS_K = THR_OFS[k*OFF_W +: OFF_W];
    localparam int OFS_I = int'(OFS_K);

    rsc_stage #(
      .IDX    (k),
      .STAGES (STAGES),
      .RES_W  (RES_W),
      .REF_I  (REF_I),
      .OFFSET (OFS_I)
    ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .vld_i   (vld_c[k]),
      .res_i   (res_c[k]),
      .codes_i (code_c[k]),
      .vld_o   (vld_c[k+1]),
      .res_o   (res_c[k+1]),
      .codes_o (code_c[k+1])
    );

    if (OFS_I == 0) begin : g_band
      // R3: ideal stage keeps an in-band residue in band
      a_r3_inband: assert property (@(posedge clk) disable iff (rst)
        (vld_c[k] && (res_c[k] >= -REF_S) && (res_c[k] <= REF_S))
        |=> ((res_c[k+1] >= -REF_S) && (res_c[k+1] <= REF_S)));
    end

    // R2: no stage field at the output holds the unused code 11
    a_r2_codes_legal: assert property (@(posedge clk) disable iff (rst)
      vld_c[STAGES] |-> (code_c[STAGES][2*k +: 2] != 2'b11));
  end

  always_comb begin
    codes_o     = code_c[STAGES];
    codes_vld_o = vld_c[STAGES];
  end

endmodule

// File: tb/test_rsc_chain.sv
`timescale 1ns/1ps
module test_rsc_chain;

  localparam int FRAC_W = 6;
  localparam int NS     = 5;
  localparam int OFF_W  = 6;
  localparam int DATA_W = FRAC_W + 1;
  localparam int CW     = 2 * NS;
  localparam int REF    = 1 << (FRAC_W - 1);
  localparam int QTR    = REF / 4;
  localparam int RMAX   = (1 << (DATA_W)) - 1;
  localparam int RMIN   = -(1 << (DATA_W));
  localparam int OFS_A [NS] = '{0, 0, 0, 0, 0};
  localparam int OFS_B [NS] = '{0, 5, 0, -6, 0};
  localparam logic [NS*OFF_W-1:0] OFS_PACK =
    {6'b000000, 6'b111010, 6'b000000, 6'b000101, 6'b000000};

  typedef struct {
    int            x;
    logic [CW-1:0] ea;
    logic [CW-1:0] eb;
    bit            clamp;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [DATA_W-1:0] smp = '0;
  logic [CW-1:0] co_a, co_b;
  logic va, vb;

  int n_vec = 0;
  int n_bad = 0;
  int n_in  = 0;
  int n_out = 0;
  bit mon_on = 1'b0;
  logic [CW-1:0] prev_a = '0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rsc_chain #(.FRAC_W(FRAC_W), .STAGES(NS), .OFF_W(OFF_W), .THR_OFS('0)) i_rsc_chain (
    .clk(clk), .rst(rst), .sample_i(smp), .sample_vld_i(vld),
    .codes_o(co_a), .codes_vld_o(va));

  rsc_chain #(.FRAC_W(FRAC_W), .STAGES(NS), .OFF_W(OFF_W), .THR_OFS(OFS_PACK)) i_rsc_chain_ofs (
    .clk(clk), .rst(rst), .sample_i(smp), .sample_vld_i(vld),
    .codes_o(co_b), .codes_vld_o(vb));

  function automatic logic [CW-1:0] model(input int x, input int ofs [NS], output bit clamp);
    int r, n, c;
    logic [CW-1:0] cv;
    r = x; cv = '0; clamp = 1'b0;
    for (int k = 0; k < NS; k++) begin
      if (r < -QTR + ofs[k])     begin c = 0; n = 2 * r + REF; end
      else if (r > QTR + ofs[k]) begin c = 2; n = 2 * r - REF; end
      else                       begin c = 1; n = 2 * r;       end
      if (n > RMAX)      begin n = RMAX; clamp = 1'b1; end
      else if (n < RMIN) begin n = RMIN; clamp = 1'b1; end
      cv[2*k +: 2] = 2'(c);
      r = n;
    end
    return cv;
  endfunction

  function automatic int recon(input logic [CW-1:0] c);
    int e = 0;
    for (int k = 0; k < NS; k++) e += (int'(c[2*k +: 2]) - 1) * (1 << (NS - 1 - k));
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int x);
    exp_t e;
    bit cl, dummy;
    smp = x[DATA_W-1:0];
    vld = v;
    if (v) begin
      e.x     = x;
      e.ea    = model(x, OFS_A, cl);
      e.clamp = cl;
      e.eb    = model(x, OFS_B, dummy);
      q.push_back(e);
      n_in++;
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      exp_t e;
      int d;
      chk_int(va == vb, "R7 valid timing equal across builds", int'(vb), int'(va));
      if (va) begin
        n_out++;
        if (q.size() == 0) begin
          chk_int(0, "R5 output without input", n_out, n_in);
        end else begin
          e = q.pop_front();
          if (e.clamp) chk(co_a === e.ea, "R4 clamped residue codes", co_a, e.ea);
          else         chk(co_a === e.ea, "R2 R3 region codes", co_a, e.ea);
          chk(co_b === e.eb, "R7 offset build codes", co_b, e.eb);
          if (e.x >= -REF && e.x <= REF) begin
            d = recon(co_b) - recon(co_a);
            chk_int(d >= -2 && d <= 2, "R8 reconstruction distance", d, 0);
          end
        end
      end else begin
        chk(co_a === prev_a, "R6 hold while idle", co_a, prev_a);
      end
      prev_a = co_a;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk_int(va == 1'b0 && vb == 1'b0, "R1 valid low in reset", int'(va), 0);
    chk(co_a == '0 && co_b == '0, "R1 codes zero in reset", co_a | co_b, '0);
    rst = 1'b0;
    mon_on = 1'b1;

    // exhaustive back-to-back sweep, full scale included
    for (int x = -(1 << FRAC_W); x < (1 << FRAC_W); x++) begin
      @(negedge clk);
      drive(1'b1, x);
    end
    @(negedge clk); drive(1'b0, 0);
    repeat (NS + 4) @(negedge clk);
    chk_int(n_out == n_in, "R5 sweep output count", n_out, n_in);

    // gapped sweep, sample changes on idle cycles
    for (int i = 0; i < 192; i++) begin
      @(negedge clk);
      drive(i % 3 != 1, ((i * 37) % 128) - 64);
    end
    @(negedge clk); drive(1'b0, 0);
    repeat (NS + 4) @(negedge clk);
    chk_int(n_out == n_in, "R6 gapped output count", n_out, n_in);

    // single sample latency
    @(negedge clk); drive(1'b1, 20);
    @(negedge clk); drive(1'b0, -50);
    lat = 1;
    while (!va && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk_int(lat == NS, "R5 latency in edges", lat, NS);
    repeat (4) @(negedge clk);
    chk_int(q.size() == 0, "R5 all samples delivered", q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule